// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked request port inside the chip and an external asynchronous static RAM of 2^19 bytes. A client presents a request together with a write flag, a 19-bit address and a write byte. The request is taken on a clock edge where `ready` is high. The sequencer then drives the RAM's active-low select, output-enable and write strobes and its split data bus for a fixed number of clock cycles. For a read it returns the byte on `rdata`, marked by a one-cycle `rvalid` pulse.

Every phase length is an integer cycle count. It is derived from the RAM's nanosecond limits and the clock period, both given as parameters. A read holds select and output-enable low for the access phase. The byte is captured on the edge that closes that phase. A turnaround phase with the RAM deselected follows, so the RAM's output drivers have floated before the controller can drive the bus again. A write holds select and write-enable low with output-enable high, and drives the data bus. Write-enable then rises as the terminating edge while select, address and data are held for one more cycle. Between accesses the RAM is deselected and the bus is released.

Top module: `sram_async_ctrl`

## Requirements
- R1: After a synchronous reset, and in every cycle with no access in progress, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `ready` is 1 and `rvalid` is 0.
- R2: A request is taken on the rising edge where `req` and `ready` are both 1, and `ready` is 0 in the following cycle.
- R3: A read drives `mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0 for the read access phase (2 cycles by default) starting the cycle after acceptance.
- R4: `rdata` holds the value on `mem_dq_in` at the edge that ends the last read access cycle. `rvalid` is a single-cycle pulse in the cycle after that edge, i.e. read-access-cycles + 1 cycles after the accepting edge.
- R5: A write drives `mem_ce_n`=0, `mem_we_n`=0, `mem_oe_n`=1 and `mem_dq_oe`=1 with `mem_dq_out` equal to the accepted byte, for exactly the write pulse phase (2 cycles by default).
- R6: The write ends by `mem_we_n` rising while `mem_ce_n` stays 0 and `mem_dq_oe` stays 1 for one further cycle, with address and data unchanged, so the byte present at that rising edge is the one stored.
- R7: After a read, `mem_dq_oe` stays 0 for at least the turnaround phase (1 cycle by default) after `mem_oe_n` returns high, and `mem_dq_oe` is never 1 while the RAM is enabled to drive (`mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1).
- R8: Address and write byte are registered at acceptance; changes on `req_addr`, `req_wdata` or `req_we` during an access have no effect on `mem_addr` or `mem_dq_out`.
- R9: `ready` is 0 for write-pulse + 1 cycles after a write is accepted and for read-access + turnaround cycles after a read is accepted (3 and 3 by default), and is 0 whenever `mem_ce_n` is 0.
- R10: A phase-length parameter below its nanosecond minimum is raised to ceil(limit / clock period). With a 4 ns clock and all phase parameters set to 1, the read access becomes 3 cycles, the write pulse 2 cycles and the turnaround 2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (19) | Byte address |
| req_wdata | input | DATA_W (8) | Byte to write |
| ready | output | 1 | Sequencer can take a request this cycle |
| rdata | output | DATA_W (8) | Byte returned by the last read |
| rvalid | output | 1 | One-cycle pulse marking new `rdata` |
| mem_addr | output | ADDR_W (19) | RAM address pins |
| mem_ce_n | output | 1 | RAM select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | DATA_W (8) | Data toward the RAM |
| mem_dq_oe | output | 1 | Enable for the pad driver of `mem_dq_out` |
| mem_dq_in | input | DATA_W (8) | Data from the RAM pins |

## Verification
The collision of interest is the end of a read with the start of a write. The `rvalid` pulse of a read falls in the same cycle as a new request that is already waiting, and the write that follows wants the bus the RAM has just stopped driving. The bench provokes this by chaining every read of a sweep straight into a write, with the next request raised in the `rvalid` cycle. A bus model that drives `mem_dq_in` only while the RAM is enabled to read flags any cycle in which both sides drive. Each chained read is judged on its captured byte and on its `rvalid` cycle, and each write on the byte the model latched at the rising write-enable edge.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ACC   = 3'd1,
        ST_RD_TURN  = 3'd2,
        ST_WR_PULSE = 3'd3,
        ST_WR_HOLD  = 3'd4
    } seq_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } cap_reg_t;

    cap_reg_t cap_d, cap_q;

    always_comb begin
        cap_d        = cap_q;
        cap_d.rvalid = cap_en;
        if (cap_en) begin
            cap_d.rdata = dq_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rdata  = cap_q.rdata;
    assign rvalid = cap_q.rvalid;

    // R4: the valid strobe never stretches past one cycle
    assert_rvalid_single_R4: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

    // R4: the returned byte does not move except on a capture
    assert_rdata_held_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(cap_en) |-> $stable(rdata));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 2,
    parameter int RD_CYC   = 2,
    parameter int WR_CYC   = 2,
    parameter int TURN_CYC = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              cap_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);

    localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
        logic              ready;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        cap_en = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (req) begin
                    seq_d.addr  = req_addr;
                    seq_d.wdata = req_wdata;
                    seq_d.cnt   = '0;
                    seq_d.ready = 1'b0;
                    seq_d.ce_n  = 1'b0;
                    if (req_we) begin
                        seq_d.state = ST_WR_PULSE;
                        seq_d.we_n  = 1'b0;
                        seq_d.oe_n  = 1'b1;
                        seq_d.dq_oe = 1'b1;
                    end else begin
                        seq_d.state = ST_RD_ACC;
                        seq_d.we_n  = 1'b1;
                        seq_d.oe_n  = 1'b0;
                        seq_d.dq_oe = 1'b0;
                    end
                end
            end
            ST_RD_ACC: begin
                if (seq_q.cnt == RD_LAST) begin
                    cap_en      = 1'b1;
                    seq_d.state = ST_RD_TURN;
                    seq_d.cnt   = '0;
                    seq_d.ce_n  = 1'b1;
                    seq_d.oe_n  = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_RD_TURN: begin
                if (seq_q.cnt == TURN_LAST) begin
                    seq_d.state = ST_IDLE;
                    seq_d.cnt   = '0;
                    seq_d.ready = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_WR_PULSE: begin
                if (seq_q.cnt == WR_LAST) begin
                    seq_d.state = ST_WR_HOLD;
                    seq_d.cnt   = '0;
                    seq_d.we_n  = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            ST_WR_HOLD: begin
                seq_d.state = ST_IDLE;
                seq_d.ce_n  = 1'b1;
                seq_d.dq_oe = 1'b0;
                seq_d.ready = 1'b1;
            end
            default: begin
                seq_d.state = ST_IDLE;
                seq_d.ce_n  = 1'b1;
                seq_d.oe_n  = 1'b1;
                seq_d.we_n  = 1'b1;
                seq_d.dq_oe = 1'b0;
                seq_d.ready = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.state <= ST_IDLE;
            seq_q.cnt   <= '0;
            seq_q.addr  <= '0;
            seq_q.wdata <= '0;
            seq_q.ce_n  <= 1'b1;
            seq_q.oe_n  <= 1'b1;
            seq_q.we_n  <= 1'b1;
            seq_q.dq_oe <= 1'b0;
            seq_q.ready <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ready      = seq_q.ready;
    assign mem_addr   = seq_q.addr;
    assign mem_dq_out = seq_q.wdata;
    assign mem_ce_n   = seq_q.ce_n;
    assign mem_oe_n   = seq_q.oe_n;
    assign mem_we_n   = seq_q.we_n;
    assign mem_dq_oe  = seq_q.dq_oe;

    // Checker state: length of the current write-enable low pulse and
    // cycles elapsed since output enable was last seen low.
    logic [CNT_W:0] we_low_q;
    logic [CNT_W:0] since_rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_low_q   <= '0;
            since_rd_q <= (CNT_W+1)'(TURN_CYC);
        end else begin
            we_low_q <= mem_we_n ? '0 : we_low_q + 1'b1;
            if (!mem_oe_n) begin
                since_rd_q <= '0;
            end else if (since_rd_q < (CNT_W+1)'(TURN_CYC)) begin
                since_rd_q <= since_rd_q + 1'b1;
            end
        end
    end

    assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (rst)
        ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (ready && req) |=> !ready);

    assert_read_no_drive_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dq_oe));

    assert_write_oe_high_R5: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

    assert_we_pulse_len_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_low_q == (CNT_W+1)'(WR_CYC)));

    assert_write_end_hold_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out)));

    assert_turnaround_R7: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (since_rd_q >= (CNT_W+1)'(TURN_CYC)));

    assert_addr_held_R8: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    assert_wdata_held_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    assert_busy_while_selected_R9: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> !ready);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int RD_ACC_CYC    = 2,
    parameter int WR_PULSE_CYC  = 2,
    parameter int TURN_CYC      = 1,
    parameter int T_ACCESS_NS   = 10,
    parameter int T_RD_CYCLE_NS = 10,
    parameter int T_WE_PULSE_NS = 7,
    parameter int T_DSETUP_NS   = 6,
    parameter int T_WR_CYCLE_NS = 10,
    parameter int T_FLOAT_NS    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    // Minimum cycle counts implied by the nanosecond limits.
    localparam int RD_MIN   = ceil_div(imax(T_ACCESS_NS, T_RD_CYCLE_NS), CLK_PERIOD_NS);
    localparam int WR_MIN_P = ceil_div(imax(T_WE_PULSE_NS, T_DSETUP_NS), CLK_PERIOD_NS);
    localparam int WR_MIN_C = ceil_div(T_WR_CYCLE_NS, CLK_PERIOD_NS) - 1;
    localparam int TURN_MIN = ceil_div(T_FLOAT_NS, CLK_PERIOD_NS);

    // Effective phase lengths: requested value, raised to the minimum.
    localparam int RD_EFF   = imax(imax(RD_ACC_CYC, RD_MIN), 1);
    localparam int WR_EFF   = imax(imax(WR_PULSE_CYC, WR_MIN_P), imax(WR_MIN_C, 1));
    localparam int TURN_EFF = imax(imax(TURN_CYC, TURN_MIN), 1);
    localparam int CNT_W    = $clog2(imax(imax(RD_EFF, WR_EFF), TURN_EFF) + 1);

    logic cap_en;

    sram_seq_fsm #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CNT_W    (CNT_W),
        .RD_CYC   (RD_EFF),
        .WR_CYC   (WR_EFF),
        .TURN_CYC (TURN_EFF)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .ready      (ready),
        .cap_en     (cap_en),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe)
    );

    sram_rd_capture #(
        .DATA_W (DATA_W)
    ) cap_i (
        .clk    (clk),
        .rst    (rst),
        .cap_en (cap_en),
        .dq_in  (mem_dq_in),
        .rdata  (rdata),
        .rvalid (rvalid)
    );

    // R4: a capture happens only while the RAM is enabled to drive
    assert_capture_during_read_R4: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> ($past(!mem_ce_n) && $past(!mem_oe_n)));

endmodule

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 19;
    localparam int DW   = 8;
    localparam int RD   = 2;
    localparam int WR   = 2;
    localparam int TURN = 1;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          ready, rvalid;
    logic [DW-1:0] rdata;
    logic [AW-1:0] mem_addr;
    logic          ce_n, oe_n, we_n, dq_oe;
    logic [DW-1:0] dq_out;
    logic [DW-1:0] dq_in = 8'hC3;

    // second instance for the clamp check, 4 ns period, all phases set to 1
    logic          c_req = 1'b0;
    logic          c_we = 1'b0;
    logic          c_ready, c_rvalid;
    logic [DW-1:0] c_rdata;
    logic [AW-1:0] c_addr;
    logic          c_ce_n, c_oe_n, c_we_n, c_dq_oe;
    logic [DW-1:0] c_dq_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_async_ctrl dut_i (
        .clk (clk), .rst (rst), .req (req), .req_we (req_we),
        .req_addr (req_addr), .req_wdata (req_wdata), .ready (ready),
        .rdata (rdata), .rvalid (rvalid), .mem_addr (mem_addr),
        .mem_ce_n (ce_n), .mem_oe_n (oe_n), .mem_we_n (we_n),
        .mem_dq_out (dq_out), .mem_dq_oe (dq_oe), .mem_dq_in (dq_in)
    );

    sram_async_ctrl #(
        .CLK_PERIOD_NS (4), .RD_ACC_CYC (1), .WR_PULSE_CYC (1), .TURN_CYC (1)
    ) dut_clamp_i (
        .clk (clk), .rst (rst), .req (c_req), .req_we (c_we),
        .req_addr (19'h00055), .req_wdata (8'h3C), .ready (c_ready),
        .rdata (c_rdata), .rvalid (c_rvalid), .mem_addr (c_addr),
        .mem_ce_n (c_ce_n), .mem_oe_n (c_oe_n), .mem_we_n (c_we_n),
        .mem_dq_out (c_dq_out), .mem_dq_oe (c_dq_oe), .mem_dq_in (8'h00)
    );

    // ---------------- RAM model ----------------
    logic [DW-1:0] mem [logic [AW-1:0]];
    logic mem_drv;
    assign mem_drv = !ce_n && !oe_n && we_n;

    // output becomes valid only after one full cycle of being enabled
    always @(posedge clk) begin
        if (mem_drv) dq_in <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h5A;
        else         dq_in <= 8'hC3;
    end

    // write lands on the terminating (rising) write-enable edge
    always @(posedge we_n) begin
        if (ce_n === 1'b0) begin
            chk("R6", {31'd0, dq_oe}, 32'd1);
            mem[mem_addr] = dq_out;
        end
    end

    // bus contention monitor
    always @(negedge clk) begin
        if (!rst && dq_oe && mem_drv) begin
            n_chk++;
            n_fail++;
            $display("FAIL R7 bus contention at %0t actual=1 expected=0", $time);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input int salt);
        int v;
        v = int'(a) * 13 + (int'(a) >> 8) + salt;
        return v[7:0];
    endfunction

    // caller sits just after a negedge; returns at a negedge
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int k;
        int lows;
        req = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
        while (!ready) @(negedge clk);
        @(negedge clk);
        req = 1'b0; req_we = 1'b0; req_addr = ~a; req_wdata = ~d;   // R8 disturbance
        chk("R2", {31'd0, ready}, 32'd0);
        chk("R5", {28'd0, ce_n, oe_n, we_n, dq_oe}, 32'b0101);
        chk("R8", {13'd0, mem_addr}, {13'd0, a});
        chk("R8", {24'd0, dq_out}, {24'd0, d});
        k = 1;
        lows = 0;
        while (!ready && k < 20) begin
            if (!we_n) lows++;
            if (k == WR + 1) chk("R6", {29'd0, we_n, ce_n, dq_oe}, 32'b101);
            @(negedge clk);
            k++;
        end
        chk("R5", lows, WR);
        chk("R9", k, WR + 2);
        chk("R6", {24'd0, mem.exists(a) ? mem[a] : 8'hxx}, {24'd0, d});
        chk("R1", {27'd0, ce_n, oe_n, we_n, dq_oe, rvalid}, 32'b11100);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input bit chain);
        int k;
        req = 1'b1; req_we = 1'b0; req_addr = a;
        while (!ready) @(negedge clk);
        @(negedge clk);
        req = 1'b0; req_we = 1'b1; req_addr = ~a;                   // R8 disturbance
        chk("R3", {28'd0, ce_n, oe_n, we_n, dq_oe}, 32'b0010);
        chk("R8", {13'd0, mem_addr}, {13'd0, a});
        k = 1;
        while (!rvalid && k < 20) begin
            @(negedge clk);
            k++;
        end
        chk("R4", k, RD + 1);
        chk("R4", {24'd0, rdata}, {24'd0, exp});
        chk("R7", {30'd0, oe_n, dq_oe}, 32'b10);
        if (!chain) begin
            @(negedge clk);
            k++;
            chk("R4", {31'd0, rvalid}, 32'd0);
            while (!ready && k < 20) begin
                @(negedge clk);
                k++;
            end
            chk("R9", k, RD + TURN + 1);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int k;
        int lows;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", {26'd0, ce_n, oe_n, we_n, dq_oe, ready, rvalid}, 32'b111010);
        chk("R1", {29'd0, c_ready, c_dq_oe, c_ce_n}, 32'b101);

        // walking-one addresses plus all-zero and all-one, write then read
        for (int b = -1; b <= AW; b++) begin
            logic [AW-1:0] a;
            a = (b < 0) ? '0 : (b == AW) ? '1 : (AW'(1) << b);
            do_write(a, pat(a, 7));
        end
        for (int b = -1; b <= AW; b++) begin
            logic [AW-1:0] a;
            a = (b < 0) ? '0 : (b == AW) ? '1 : (AW'(1) << b);
            do_read(a, pat(a, 7), 1'b0);
        end

        // block sweep: read chained straight into the next write
        for (int i = 0; i < 64; i++) do_write(AW'(19'h2A000 + i), pat(AW'(19'h2A000 + i), 1));
        for (int i = 0; i < 64; i++) begin
            do_read(AW'(19'h2A000 + i), pat(AW'(19'h2A000 + i), 1), 1'b1);
            do_write(AW'(19'h2A000 + i), pat(AW'(19'h2A000 + i), 99));
        end
        for (int i = 0; i < 64; i++) do_read(AW'(19'h2A000 + i), pat(AW'(19'h2A000 + i), 99), 1'b0);

        // overwrite the same location, read after write with no address change
        do_write(19'h7FFFE, 8'h00);
        do_write(19'h7FFFE, 8'hFF);
        do_read(19'h7FFFE, 8'hFF, 1'b0);

        // R10: clamped instance, write pulse 2, read access 3, turnaround 2
        @(negedge clk);
        c_req = 1'b1; c_we = 1'b1;
        @(negedge clk);
        c_req = 1'b0;
        k = 1; lows = 0;
        while (!c_ready && k < 20) begin
            if (!c_we_n) lows++;
            @(negedge clk);
            k++;
        end
        chk("R10", lows, 2);
        chk("R10", k, 4);
        c_req = 1'b1; c_we = 1'b0;
        @(negedge clk);
        c_req = 1'b0;
        k = 1; lows = 0;
        while (!c_rvalid && k < 20) begin
            if (!c_oe_n) lows++;
            @(negedge clk);
            k++;
        end
        chk("R10", lows, 3);
        chk("R10", k, 4);
        while (!c_ready && k < 20) begin
            @(negedge clk);
            k++;
        end
        chk("R10", k, 6);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule